// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a compact one-address processor built around a single accumulator. It steps through each instruction as a short chain of register transfers. A program counter feeds an address register, and a synchronous word memory returns the word through its data register. That word moves into an instruction register. An execute phase then routes the 12-bit operand field back through the address register to reach data, or hands it to the I/O ports as a device number. Instructions and data share one memory inside the block.

The program is written into the memory through a loader port while reset is held. When reset is released, the core starts at address 0 and runs until it meets a halt. Input values come in through a valid/ready port. The core raises `in_ready` only while an input instruction is waiting, and it loads the accumulator on the cycle that both `in_valid` and `in_ready` are high. Results leave through a valid/ready port. `out_valid` stays high with stable data and device number until the consumer raises `out_ready`, so a slow consumer simply stalls the core. `dev_sel` carries the operand field of the current input or output instruction.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is low and on the first cycles after it is released, `halted`, `in_ready` and `out_valid` are 0. The accumulator starts at 0 and execution begins at word address 0.
- R2: An instruction word holds the opcode in bits 15:12 and the operand in bits 11:0. The low ADDR_W bits of the operand select a memory word.
- R3: Opcode 1 copies the memory word to the accumulator. Opcode 2 adds the word to it and opcode 4 subtracts the word from it, both wrapping modulo 2^16. Opcode 3 writes the accumulator to the memory word.
- R4: Opcode 8 continues execution at the word given by the operand.
- R5: Opcodes 9, 10 and 11 skip the next instruction when the accumulator is, respectively, zero, positive and non-zero, or negative in two's complement. Otherwise execution continues with the next instruction.
- R6: Opcode 0 and opcodes 12 to 15 change nothing and go on to the next instruction.
- R7: Opcode 5 raises `in_ready` with `dev_sel` equal to the operand. It stays there until `in_valid` is seen high, and then the accumulator takes `in_data`.
- R8: Opcode 6 raises `out_valid` with `out_data` equal to the accumulator and `dev_sel` equal to the operand. All three hold steady until `out_ready` is high on a clock edge.
- R9: Opcode 7 sets `halted`. It stays set until reset, and no further input or output transfer starts.
- R10: Loader writes take effect only while reset is low. Loader writes made while the core runs leave memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_we | input | 1 | Loader write enable (used only in reset) |
| ld_addr | input | ADDR_W | Loader word address |
| ld_data | input | 16 | Loader word value |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Core is waiting on an input instruction |
| in_data | input | 16 | Input value |
| out_valid | output | 1 | Output value offered |
| out_ready | input | 1 | Consumer accepts the output value |
| out_data | output | 16 | Accumulator value being output |
| dev_sel | output | 12 | Device number of the current I/O instruction |
| halted | output | 1 | Core has stopped |

## Verification
The handshake properties assume the environment follows the port rules. An offered output stays pending until `out_ready` is seen, and the input wait ends only through `in_valid`. The bench drives both strobes only at falling edges and never withdraws a value that the core has not yet taken. The properties also assume that the memory is loaded only under reset. Every scenario writes its program and data while `rst_n` is low and releases reset only afterwards. The one exception is the scenario that deliberately drives the loader mid-run to show that it has no effect.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_LOAD  = 4'd1,
    OP_ADD   = 4'd2,
    OP_STORE = 4'd3,
    OP_SUB   = 4'd4,
    OP_IN    = 4'd5,
    OP_OUT   = 4'd6,
    OP_HALT  = 4'd7,
    OP_JMP   = 4'd8,
    OP_SKZ   = 4'd9,
    OP_SKP   = 4'd10,
    OP_SKN   = 4'd11
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FADDR, ST_FREAD, ST_FDEC, ST_X0, ST_X1, ST_X2, ST_IN, ST_OUT, ST_HALT
  } state_e;

  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB} alu_op_e;
endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] words_q [DEPTH];

  // rdata is the machine's memory data register
  always_ff @(posedge clk) begin
    if (we) words_q[waddr] <= wdata;
    if (re) rdata <= words_q[raddr];
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/acc_cpu_flags.sv
module acc_cpu_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] acc,
  output logic         zf,
  output logic         pf,
  output logic         nf
);
  always_comb begin
    zf = (acc == '0);
    nf = acc[W-1];
    pf = !acc[W-1] && (acc != '0);
  end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_we,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  logic [DATA_W-1:0]     ld_data,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DATA_W-1:0]     in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DATA_W-1:0]     out_data,
  output logic [DATA_W-OP_W-1:0] dev_sel,
  output logic                  halted
);
  localparam int FIELD_W = DATA_W - OP_W;

  state_e            st_q;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, acc_q, mdr;
  opcode_e           op;
  alu_op_e           alu_op;
  logic [DATA_W-1:0] alu_y;
  logic              zf, pf, nf;
  logic              core_we, mem_we, mem_re;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  assign op = opcode_e'(ir_q[DATA_W-1 -: OP_W]);

  // memory port sharing: loader owns the write side only under reset (R10)
  always_comb begin
    core_we   = (st_q == ST_X1) && (op == OP_STORE);
    mem_re    = (st_q == ST_FREAD) || ((st_q == ST_X1) && (op != OP_STORE));
    mem_we    = rst_n ? core_we : ld_we;
    mem_waddr = rst_n ? mar_q : ld_addr;
    mem_wdata = rst_n ? acc_q : ld_data;
  end

  acc_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mar_q), .rdata(mdr)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  alu_op = ALU_ADD;
      OP_SUB:  alu_op = ALU_SUB;
      default: alu_op = ALU_PASS;
    endcase
  end

  acc_cpu_alu #(.W(DATA_W)) alu_i (.op(alu_op), .a(acc_q), .b(mdr), .y(alu_y));
  acc_cpu_flags #(.W(DATA_W)) flags_i (.acc(acc_q), .zf(zf), .pf(pf), .nf(nf));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_FADDR;
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      unique case (st_q)
        ST_FADDR: begin
          mar_q <= pc_q;
          st_q  <= ST_FREAD;
        end
        ST_FREAD: st_q <= ST_FDEC;
        ST_FDEC: begin
          ir_q <= mdr;
          pc_q <= pc_q + 1'b1;
          st_q <= ST_X0;
        end
        ST_X0: begin
          st_q <= ST_FADDR;
          unique case (op)
            OP_LOAD, OP_ADD, OP_SUB, OP_STORE: begin
              mar_q <= ir_q[ADDR_W-1:0];
              st_q  <= ST_X1;
            end
            OP_JMP:  pc_q <= ir_q[ADDR_W-1:0];
            OP_SKZ:  if (zf) pc_q <= pc_q + 1'b1;
            OP_SKP:  if (pf) pc_q <= pc_q + 1'b1;
            OP_SKN:  if (nf) pc_q <= pc_q + 1'b1;
            OP_HALT: st_q <= ST_HALT;
            OP_IN:   st_q <= ST_IN;
            OP_OUT:  st_q <= ST_OUT;
            default: st_q <= ST_FADDR;
          endcase
        end
        ST_X1: st_q <= (op == OP_STORE) ? ST_FADDR : ST_X2;
        ST_X2: begin
          acc_q <= alu_y;
          st_q  <= ST_FADDR;
        end
        ST_IN: if (in_valid) begin
          acc_q <= in_data;
          st_q  <= ST_FADDR;
        end
        ST_OUT: if (out_ready) st_q <= ST_FADDR;
        default: st_q <= ST_HALT;
      endcase
    end
  end

  assign in_ready  = (st_q == ST_IN);
  assign out_valid = (st_q == ST_OUT);
  assign out_data  = acc_q;
  assign dev_sel   = ir_q[FIELD_W-1:0];
  assign halted    = (st_q == ST_HALT);

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({zf, pf, nf}));
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(dev_sel));
  a_r7_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> in_ready && $stable(acc_q));
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !out_valid && !in_ready);
  a_r3_acc_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> ($past(st_q) == ST_X2) || ($past(st_q) == ST_IN));
  a_r10_no_write_running: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (st_q == ST_X1));
endmodule

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;
  localparam int AW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [15:0] ld_data = '0, in_data = '0, out_data;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1, halted;
  logic [11:0] dev_sel;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  acc_cpu_core #(.DATA_W(16), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .dev_sel(dev_sel), .halted(halted)
  );

  function automatic logic [15:0] w(input int op, input int arg);
    return 16'((op << 12) | (arg & 12'hFFF));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    ld_we = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    for (int i = 0; i < 64; i++) poke(i, w(7, 0));
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic expect_out(input string req, input int dev, input logic [15:0] val);
    int n = 0;
    while (!out_valid && n < 300) begin @(negedge clk); n++; end
    chk({req, " out_valid"}, 32'(out_valid), 32'd1);
    chk({req, " dev_sel"}, 32'(dev_sel), 32'(dev));
    chk({req, " out_data"}, 32'(out_data), 32'(val));
    if (out_ready) @(negedge clk);
  endtask

  task automatic expect_halt(input string req);
    int n = 0;
    while (!halted && n < 300) begin @(negedge clk); n++; end
    chk({req, " halted"}, 32'(halted), 32'd1);
  endtask

  task automatic t_reset_state();
    hold_reset();
    poke(0, w(6, 9)); poke(1, w(7, 0));
    chk("R1 halted in reset", 32'(halted), 0);
    chk("R1 out_valid in reset", 32'(out_valid), 0);
    release_reset();
    chk("R1 in_ready after reset", 32'(in_ready), 0);
    chk("R1 out_valid after reset", 32'(out_valid), 0);
    expect_out("R1 acc zero from word 0", 9, 16'h0000);
    expect_halt("R9 after R1 program");
  endtask

  task automatic t_arith();
    hold_reset();
    poke(32, 16'd1245); poke(33, 16'd1755);
    poke(0, w(1, 32)); poke(1, w(2, 33)); poke(2, w(3, 34));
    poke(3, w(4, 34)); poke(4, w(6, 1)); poke(5, w(2, 34));
    poke(6, w(6, 2)); poke(7, w(7, 0));
    release_reset();
    expect_out("R3 sub of stored sum", 1, 16'd0);
    expect_out("R3 R2 load add store", 2, 16'd3000);
    expect_halt("R9 arith");
  endtask

  task automatic t_wrap();
    hold_reset();
    poke(32, 16'h8000); poke(33, 16'h0001); poke(34, 16'h7FFF);
    poke(0, w(1, 32)); poke(1, w(4, 33)); poke(2, w(6, 3));
    poke(3, w(1, 34)); poke(4, w(2, 33)); poke(5, w(6, 4)); poke(6, w(7, 0));
    release_reset();
    expect_out("R3 sub wraps", 3, 16'h7FFF);
    expect_out("R3 add wraps", 4, 16'h8000);
  endtask

  task automatic t_skips();
    hold_reset();
    poke(32, 16'd0); poke(33, 16'd5); poke(34, 16'hFFFD);
    poke(0, w(1, 32)); poke(1, w(9, 0)); poke(2, w(6, 1)); poke(3, w(10, 0));
    poke(4, w(6, 2)); poke(5, w(1, 33)); poke(6, w(10, 0)); poke(7, w(6, 3));
    poke(8, w(11, 0)); poke(9, w(6, 4)); poke(10, w(1, 34)); poke(11, w(11, 0));
    poke(12, w(6, 5)); poke(13, w(9, 0)); poke(14, w(6, 6)); poke(15, w(7, 0));
    release_reset();
    expect_out("R5 zero skip then positive no-skip", 2, 16'd0);
    expect_out("R5 positive skip then negative no-skip", 4, 16'd5);
    expect_out("R5 negative skip then zero no-skip", 6, 16'hFFFD);
    expect_halt("R9 skips");
  endtask

  task automatic t_jump_nop();
    hold_reset();
    poke(32, 16'h0ABC);
    poke(0, w(8, 5)); poke(1, w(6, 1)); poke(5, w(0, 32)); poke(6, w(12, 32));
    poke(7, w(15, 0)); poke(8, w(1, 32)); poke(9, w(6, 3)); poke(10, w(7, 0));
    release_reset();
    expect_out("R4 R6 jump over, nops inert", 3, 16'h0ABC);
  endtask

  task automatic t_input();
    int n = 0;
    hold_reset();
    poke(32, 16'd1);
    poke(0, w(5, 5)); poke(1, w(2, 32)); poke(2, w(6, 9)); poke(3, w(7, 0));
    release_reset();
    while (!in_ready && n < 100) begin @(negedge clk); n++; end
    chk("R7 in_ready raised", 32'(in_ready), 1);
    chk("R7 dev_sel on input", 32'(dev_sel), 5);
    repeat (4) @(negedge clk);
    chk("R7 waits for in_valid", 32'(in_ready), 1);
    in_valid = 1'b1; in_data = 16'h1234;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 in_ready drops after take", 32'(in_ready), 0);
    expect_out("R7 input value used", 9, 16'h1235);
  endtask

  task automatic t_backpressure();
    hold_reset();
    poke(32, 16'h00AB);
    poke(0, w(1, 32)); poke(1, w(6, 7)); poke(2, w(7, 0));
    out_ready = 1'b0;
    release_reset();
    expect_out("R8 offered", 7, 16'h00AB);
    repeat (5) @(negedge clk);
    chk("R8 valid held", 32'(out_valid), 1);
    chk("R8 data held", 32'(out_data), 32'h00AB);
    chk("R8 dev held", 32'(dev_sel), 7);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8 released on ready", 32'(out_valid), 0);
    expect_halt("R9 backpressure");
    repeat (20) @(negedge clk);
    chk("R9 stays halted", 32'(halted), 1);
    chk("R9 no output after halt", 32'(out_valid), 0);
  endtask

  task automatic t_loader_ignored();
    hold_reset();
    poke(32, 16'h1111);
    poke(0, w(1, 32)); poke(1, w(6, 9)); poke(2, w(7, 0));
    release_reset();
    ld_we = 1'b1; ld_addr = AW'(32); ld_data = 16'hBEEF;
    expect_out("R10 running loader ignored", 9, 16'h1111);
    ld_we = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_arith();
    t_wrap();
    t_skips();
    t_jump_nop();
    t_input();
    t_backpressure();
    t_loader_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule